// File: doc/BRIEF.md
# Prioritised Interrupt Router with Vector Generation

This block gathers a bank of external interrupt lines (32 by default) and presents them to a processor as two request outputs. One is a critical request and the other is a non-critical request. Each line has its own settings, which software writes through a small register bank on a device-control style bus. That bus has a 10-bit address, 32-bit data, a write strobe and a read strobe. For each line, software chooses:
- whether the line is active high or active low,
- whether a level or an edge is detected,
- whether the line is enabled,
- which of the two outputs it is routed to.

Each line latches into a sticky status bit. Software clears that bit by writing a one to it. A status bit that is also enabled is pending. The pending lines that are marked critical drive the critical output, and all other pending lines drive the non-critical output.

For the critical path, the block also produces a ready-made handler address. This vector is a software-programmed base plus 512 times the number of the winning line. Line 0 has the highest priority. A critical handler reads this one register and branches to the address, with no need to scan the status bits.

Top module: `irq_router_top`

## Requirements
- R1: After reset the polarity register (0x0C4) reads 0xFFFFFFFF and every other register, `reg_rdata`, `crit_irq_o` and `ncrit_irq_o` are 0.
- R2: With trigger bit 0 (level), a status bit (0x0C0) sets at the clock edge where the input equals its polarity bit (1 = active high, 0 = active low). It stays set after the input goes inactive, until software clears it.
- R3: With trigger bit 1 (edge), a status bit sets only on a transition: a rising edge when polarity is 1, a falling edge when polarity is 0. An input held steady never sets it again.
- R4: Writing a 1 to a status bit clears it, and writing 0 has no effect. The clear wins over a set in the same cycle. A level source that is still active sets the bit again one cycle later.
- R5: Masked status (0x0C6, read only) equals status AND enable (0x0C2). Status bits latch whatever the enable setting, and with no masked bit set both outputs are low.
- R6: `crit_irq_o` is high exactly when some masked bit has its critical-select bit (0x0C3) at 1. `ncrit_irq_o` is high exactly when some masked bit has it at 0.
- R7: The vector register (0x0C7, read only) reads vector configuration (0x0C8) + 512 × n, where n is the lowest-numbered masked critical source. It reads 0 when no critical source is pending, and non-critical sources never influence it.
- R8: Registers 0x0C2, 0x0C3, 0x0C4, 0x0C5 and 0x0C8 read back what was written. Writes to 0x0C6, 0x0C7 or any unmapped address change nothing. Read data appears on the cycle after the read strobe, and is 0 for unmapped addresses and on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source lines, already synchronous to `clk` |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 32 | Registered read data |
| crit_irq_o | output | 1 | Critical interrupt request |
| ncrit_irq_o | output | 1 | Non-critical interrupt request |

## Verification
The assertions assume three things about the inputs:
- The source lines are already synchronous to `clk`.
- A read or a write lasts exactly one cycle, with its address and data steady during that cycle.
- A read and a write never share a cycle.

Under those assumptions, a newly set status bit can always be traced to an active input level in the cycle before. The bench keeps to these conditions by changing every input on the falling clock edge. It issues strobes only through one-cycle write and read tasks, which never overlap. It also reconfigures polarity and trigger only while the affected lines are held steady, so that no stray edge is produced.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, register selector type and address decoder
// for the interrupt router. Assumes a 10-bit register address space in
// which only eight addresses are mapped; all others decode to SEL_NONE.
package irq_router_pkg;

    localparam int REG_ADDR_W = 10;

    localparam logic [REG_ADDR_W-1:0] ADR_STAT = 10'h0C0;
    localparam logic [REG_ADDR_W-1:0] ADR_EN   = 10'h0C2;
    localparam logic [REG_ADDR_W-1:0] ADR_CRIT = 10'h0C3;
    localparam logic [REG_ADDR_W-1:0] ADR_POL  = 10'h0C4;
    localparam logic [REG_ADDR_W-1:0] ADR_TRIG = 10'h0C5;
    localparam logic [REG_ADDR_W-1:0] ADR_MSK  = 10'h0C6;
    localparam logic [REG_ADDR_W-1:0] ADR_VEC  = 10'h0C7;
    localparam logic [REG_ADDR_W-1:0] ADR_VCFG = 10'h0C8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_CRIT,
        SEL_POL,
        SEL_TRIG,
        SEL_MSK,
        SEL_VEC,
        SEL_VCFG
    } reg_sel_e;

    // Map a bus address onto the register it names.
    function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADR_STAT: s = SEL_STAT;
            ADR_EN:   s = SEL_EN;
            ADR_CRIT: s = SEL_CRIT;
            ADR_POL:  s = SEL_POL;
            ADR_TRIG: s = SEL_TRIG;
            ADR_MSK:  s = SEL_MSK;
            ADR_VEC:  s = SEL_VEC;
            ADR_VCFG: s = SEL_VCFG;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the software-written configuration of the router: enable,
// critical select, polarity, trigger mode and the vector base.
// Assumes the selector is already decoded and that wr_i is a one-cycle
// strobe. Read-only and unmapped selectors leave every field untouched.
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int                 N_SRC   = 32,
    parameter int                 DATA_W  = 32,
    parameter logic [N_SRC-1:0]   POL_RST = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  reg_sel_e            sel_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [N_SRC-1:0]    en_o,
    output logic [N_SRC-1:0]    crit_o,
    output logic [N_SRC-1:0]    pol_o,
    output logic [N_SRC-1:0]    trig_o,
    output logic [DATA_W-1:0]   vcfg_o
);

    logic [N_SRC-1:0] wfield;

    // Purpose: the per-source slice of the write data.
    always_comb begin
        wfield = wdata_i[N_SRC-1:0];
    end

    // Purpose: load the addressed configuration field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            crit_o <= '0;
            pol_o  <= POL_RST;
            trig_o <= '0;
            vcfg_o <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_EN:   en_o   <= wfield;
                SEL_CRIT: crit_o <= wfield;
                SEL_POL:  pol_o  <= wfield;
                SEL_TRIG: trig_o <= wfield;
                SEL_VCFG: vcfg_o <= wdata_i;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/irq_src_capture.sv
// Module: irq_src_capture
// Per-source detection and sticky status. Each source compares its input
// with its polarity bit. In level mode a match sets the status bit; in
// edge mode only a change into the matching value sets it. A clear
// request wins over a set in the same cycle. Assumes src_i is already
// synchronous to clk; the previous-sample register resets to 0.
module irq_src_capture #(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [N_SRC-1:0]  pol_i,
    input  logic [N_SRC-1:0]  trig_i,
    input  logic [N_SRC-1:0]  clr_i,
    output logic [N_SRC-1:0]  stat_o
);

    logic [N_SRC-1:0] src_q;

    // Purpose: keep last cycle's input sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_i;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic active;
        logic moved;
        logic set_hit;
        logic stat_q;

        // Purpose: decide whether this source requests a set this cycle.
        always_comb begin
            active  = (src_i[g] == pol_i[g]);
            moved   = (src_q[g] != src_i[g]);
            set_hit = trig_i[g] ? (active && moved) : active;
        end

        // Purpose: sticky status bit with write-one-to-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q <= 1'b0;
            end else if (clr_i[g]) begin
                stat_q <= 1'b0;
            end else if (set_hit) begin
                stat_q <= 1'b1;
            end
        end

        assign stat_o[g] = stat_q;
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority picker: returns the index of the lowest-numbered set
// request bit, and a flag that any bit is set. Purely combinational.
module irq_prio_pick #(
    parameter int N_SRC = 32,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  req_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              any_o
);

    // Purpose: scan from the top so that the lowest index is kept last.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_router_top.sv
// Module: irq_router_top
// Interrupt router: captures N_SRC source lines into sticky status bits,
// masks them with the enable register and routes them to a critical or a
// non-critical request output. It also forms a handler vector for the
// lowest-numbered pending critical source. It is accessed through a simple
// register bus whose read data is registered. Assumes N_SRC <= DATA_W and
// one-cycle read/write strobes that do not overlap.
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int N_SRC          = 32,
    parameter int DATA_W         = 32,
    parameter int VEC_STRIDE_LOG2 = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_i,
    input  logic [REG_ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    crit_irq_o,
    output logic                    ncrit_irq_o
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    reg_sel_e            sel;
    logic [N_SRC-1:0]    en_q, crit_q, pol_q, trig_q;
    logic [DATA_W-1:0]   vcfg_q;
    logic [N_SRC-1:0]    stat_q;
    logic [N_SRC-1:0]    stat_clr;
    logic [N_SRC-1:0]    masked;
    logic [N_SRC-1:0]    crit_req;
    logic [N_SRC-1:0]    ncrit_req;
    logic [IDX_W-1:0]    win_idx;
    logic                win_any;
    logic [DATA_W-1:0]   vec_val;
    logic [DATA_W-1:0]   rd_mux;

    // Purpose: decode the bus address and form the status clear mask.
    always_comb begin
        sel      = decode_addr(reg_addr);
        stat_clr = (reg_wr && sel == SEL_STAT) ? reg_wdata[N_SRC-1:0] : '0;
    end

    irq_cfg_regs #(
        .N_SRC   (N_SRC),
        .DATA_W  (DATA_W),
        .POL_RST ({N_SRC{1'b1}})
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .sel_i   (sel),
        .wdata_i (reg_wdata),
        .en_o    (en_q),
        .crit_o  (crit_q),
        .pol_o   (pol_q),
        .trig_o  (trig_q),
        .vcfg_o  (vcfg_q)
    );

    irq_src_capture #(
        .N_SRC (N_SRC)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .pol_i  (pol_q),
        .trig_i (trig_q),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    // Purpose: mask status and split it between the two request classes.
    always_comb begin
        masked    = stat_q & en_q;
        crit_req  = masked & crit_q;
        ncrit_req = masked & ~crit_q;
    end

    irq_prio_pick #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i (crit_req),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    // Purpose: vector = base + stride * winning index, zero when idle.
    always_comb begin
        if (win_any) begin
            vec_val = vcfg_q + (DATA_W'(win_idx) << VEC_STRIDE_LOG2);
        end else begin
            vec_val = '0;
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        case (sel)
            SEL_STAT: rd_mux = DATA_W'(stat_q);
            SEL_EN:   rd_mux = DATA_W'(en_q);
            SEL_CRIT: rd_mux = DATA_W'(crit_q);
            SEL_POL:  rd_mux = DATA_W'(pol_q);
            SEL_TRIG: rd_mux = DATA_W'(trig_q);
            SEL_MSK:  rd_mux = DATA_W'(masked);
            SEL_VEC:  rd_mux = vec_val;
            SEL_VCFG: rd_mux = vcfg_q;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register read data one cycle after the strobe, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end else begin
            reg_rdata <= '0;
        end
    end

    // Purpose: drive the two processor request lines.
    always_comb begin
        crit_irq_o  = |crit_req;
        ncrit_irq_o = |ncrit_req;
    end

endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Assertion checker for irq_router_top, attached by bind. Observes the
// bus, the request outputs and the internal status and configuration.
// Assumes synchronous sources and one-cycle non-overlapping strobes.
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_SRC-1:0]       src,
    input logic [REG_ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]      reg_wdata,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [DATA_W-1:0]      reg_rdata,
    input logic                   crit_irq_o,
    input logic                   ncrit_irq_o,
    input logic [N_SRC-1:0]       status,
    input logic [N_SRC-1:0]       enable,
    input logic [N_SRC-1:0]       crit_sel,
    input logic [N_SRC-1:0]       pol,
    input logic [N_SRC-1:0]       trig
);

    AST_LEVEL_SET_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((status & ~$past(status) & ~$past(trig) & ($past(src) ^ $past(pol))) == '0)); // R2
    AST_EDGE_SET_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((status & ~$past(status) & $past(trig) & ($past(src) ^ $past(pol))) == '0)); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == ADR_STAT) |=> ((status & $past(reg_wdata[N_SRC-1:0])) == '0)); // R4
    AST_IDLE_WHEN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) ((status & enable) == '0) |-> (!crit_irq_o && !ncrit_irq_o)); // R5
    AST_CRIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) crit_irq_o |-> ((status & enable & crit_sel) != '0)); // R6
    AST_NCRIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) ncrit_irq_o |-> ((status & enable & ~crit_sel) != '0)); // R6
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !reg_rd |=> (reg_rdata == '0)); // R8
    AST_RDATA_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_addr == ADR_EN) |=> (reg_rdata == DATA_W'($past(enable)))); // R8

endmodule

bind irq_router_top irq_router_chk #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (src_i),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata),
    .crit_irq_o  (crit_irq_o),
    .ncrit_irq_o (ncrit_irq_o),
    .status      (stat_q),
    .enable      (en_q),
    .crit_sel    (crit_q),
    .pol         (pol_q),
    .trig        (trig_q)
);

// File: tb/tb_irq_router_top.sv
// Directed bench for irq_router_top: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// on the falling edge after the capturing rising edge.
module tb_irq_router_top;

    localparam logic [9:0] A_STAT = 10'h0C0;
    localparam logic [9:0] A_EN   = 10'h0C2;
    localparam logic [9:0] A_CRIT = 10'h0C3;
    localparam logic [9:0] A_POL  = 10'h0C4;
    localparam logic [9:0] A_TRIG = 10'h0C5;
    localparam logic [9:0] A_MSK  = 10'h0C6;
    localparam logic [9:0] A_VEC  = 10'h0C7;
    localparam logic [9:0] A_VCFG = 10'h0C8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        crit_irq_o;
    logic        ncrit_irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_router_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_rdata   (reg_rdata),
        .crit_irq_o  (crit_irq_o),
        .ncrit_irq_o (ncrit_irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        reg_addr = '0;
        d        = reg_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
    endtask

    task automatic quiesce();
        set_src('0);
        wr_reg(A_EN, '0);
        wr_reg(A_CRIT, '0);
        wr_reg(A_TRIG, '0);
        wr_reg(A_POL, 32'hFFFF_FFFF);
        wr_reg(A_VCFG, '0);
        wr_reg(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "crit after reset", 32'(crit_irq_o), 32'h0);
        check("R1", "ncrit after reset", 32'(ncrit_irq_o), 32'h0);
        check("R1", "rdata after reset", reg_rdata, 32'h0);
        rd_reg(A_POL, d);  check("R1", "polarity reset", d, 32'hFFFF_FFFF);
        rd_reg(A_STAT, d); check("R1", "status reset", d, 32'h0);
        rd_reg(A_EN, d);   check("R1", "enable reset", d, 32'h0);
        rd_reg(A_CRIT, d); check("R1", "critsel reset", d, 32'h0);
        rd_reg(A_TRIG, d); check("R1", "trigger reset", d, 32'h0);
        rd_reg(A_VCFG, d); check("R1", "vcfg reset", d, 32'h0);
        rd_reg(A_VEC, d);  check("R1", "vector reset", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        quiesce();
        wr_reg(A_EN, 32'h0000_0008);
        set_src(32'h0000_0008);
        check("R2", "level high sets ncrit", 32'(ncrit_irq_o), 32'h1);
        check("R6", "noncrit source keeps crit low", 32'(crit_irq_o), 32'h0);
        rd_reg(A_MSK, d);  check("R5", "masked status", d, 32'h0000_0008);
        wr_reg(A_STAT, 32'h0);
        rd_reg(A_STAT, d); check("R4", "write 0 leaves status", d, 32'h0000_0008);
        wr_reg(A_STAT, 32'h0000_0008);
        check("R4", "clear visible at once", 32'(ncrit_irq_o), 32'h0);
        @(negedge clk);
        check("R4", "active level re-sets next cycle", 32'(ncrit_irq_o), 32'h1);
        set_src('0);
        rd_reg(A_STAT, d); check("R2", "level status sticky", d, 32'h0000_0008);
        wr_reg(A_STAT, 32'h0000_0008);
        rd_reg(A_STAT, d); check("R4", "cleared stays clear", d, 32'h0);
        // active-low level on source 5
        quiesce();
        wr_reg(A_EN, 32'h0000_0020);
        wr_reg(A_POL, ~32'h0000_0020);
        set_src('0);
        check("R2", "active-low level sets", 32'(ncrit_irq_o), 32'h1);
        rd_reg(A_STAT, d); check("R2", "active-low status", d, 32'h0000_0020);
        // enable gating on source 12
        quiesce();
        set_src(32'h0000_1000);
        rd_reg(A_STAT, d); check("R5", "status latches while disabled", d, 32'h0000_1000);
        rd_reg(A_MSK, d);  check("R5", "masked zero when disabled", d, 32'h0);
        check("R5", "outputs low when disabled", 32'({crit_irq_o, ncrit_irq_o}), 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        quiesce();
        wr_reg(A_TRIG, 32'h0000_0080);
        set_src(32'h0000_0080);
        rd_reg(A_STAT, d); check("R3", "rising edge sets", d, 32'h0000_0080);
        wr_reg(A_STAT, 32'h0000_0080);
        set_src(32'h0000_0080);
        rd_reg(A_STAT, d); check("R3", "held high no re-set", d, 32'h0);
        set_src('0);
        rd_reg(A_STAT, d); check("R3", "falling edge ignored when pol=1", d, 32'h0);
        // falling-edge source 9
        quiesce();
        set_src(32'h0000_0200);
        wr_reg(A_TRIG, 32'h0000_0200);
        wr_reg(A_POL, ~32'h0000_0200);
        wr_reg(A_STAT, 32'h0000_0200);
        rd_reg(A_STAT, d); check("R3", "no set before falling edge", d, 32'h0);
        set_src('0);
        rd_reg(A_STAT, d); check("R3", "falling edge sets", d, 32'h0000_0200);
    endtask

    task automatic t_route();
        logic [31:0] d;
        quiesce();
        wr_reg(A_EN, 32'h0010_0410);
        wr_reg(A_CRIT, 32'h0010_0400);
        wr_reg(A_VCFG, 32'h0000_1000);
        set_src(32'h0000_0010);
        check("R6", "noncrit pending: ncrit", 32'(ncrit_irq_o), 32'h1);
        check("R6", "noncrit pending: crit low", 32'(crit_irq_o), 32'h0);
        rd_reg(A_VEC, d); check("R7", "vector zero without crit", d, 32'h0);
        set_src(32'h0010_0010);
        check("R6", "crit pending: crit", 32'(crit_irq_o), 32'h1);
        rd_reg(A_VEC, d); check("R7", "vector source 20", d, 32'h0000_3800);
        set_src(32'h0010_0410);
        rd_reg(A_VEC, d); check("R7", "lowest crit wins (10)", d, 32'h0000_2400);
        wr_reg(A_EN, 32'h0010_0010);
        rd_reg(A_VEC, d); check("R7", "disabled source skipped", d, 32'h0000_3800);
        wr_reg(A_CRIT, 32'h0);
        check("R6", "all noncrit: crit low", 32'(crit_irq_o), 32'h0);
        check("R6", "all noncrit: ncrit", 32'(ncrit_irq_o), 32'h1);
        rd_reg(A_VEC, d); check("R7", "vector zero after reroute", d, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        quiesce();
        wr_reg(A_EN, 32'hA5A5_A5A5);   rd_reg(A_EN, d);   check("R8", "enable rw", d, 32'hA5A5_A5A5);
        wr_reg(A_CRIT, 32'h5A5A_0F0F); rd_reg(A_CRIT, d); check("R8", "critsel rw", d, 32'h5A5A_0F0F);
        wr_reg(A_TRIG, 32'h1234_5678); rd_reg(A_TRIG, d); check("R8", "trigger rw", d, 32'h1234_5678);
        wr_reg(A_VCFG, 32'hDEAD_BE00); rd_reg(A_VCFG, d); check("R8", "vcfg rw", d, 32'hDEAD_BE00);
        wr_reg(A_MSK, 32'hFFFF_FFFF);  rd_reg(A_MSK, d);  check("R8", "masked read only", d, 32'h0);
        wr_reg(A_VEC, 32'hFFFF_FFFF);  rd_reg(A_VEC, d);  check("R8", "vector read only", d, 32'h0);
        wr_reg(10'h0C1, 32'h0);        rd_reg(A_EN, d);   check("R8", "unmapped write ignored", d, 32'hA5A5_A5A5);
        wr_reg(10'h2C2, 32'h0);        rd_reg(A_EN, d);   check("R8", "alias write ignored", d, 32'hA5A5_A5A5);
        rd_reg(10'h0C1, d); check("R8", "unmapped read zero", d, 32'h0);
        rd_reg(A_EN, d);
        @(negedge clk);
        check("R8", "rdata zero without read", reg_rdata, 32'h0);
        wr_reg(A_POL, 32'h0F0F_F0F0);  rd_reg(A_POL, d);  check("R8", "polarity rw", d, 32'h0F0F_F0F0);
        quiesce();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_edge();
        t_route();
        t_regs();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule